// File: doc/BRIEF.md
# Ping-Pong OUT Endpoint DMA Drainer

This block sits between the packet receiver of a USB device OUT endpoint and an external DMA controller. The receiver writes each packet into one of two byte buffers (slot 0 and slot 1) and then reports the buffer as full, along with its byte count. While the handler is enabled, the block requests service whenever the oldest full buffer holds data. The DMA controller acknowledges the request and reads the bytes one strobe at a time.

Requests are issued in bursts of a programmable length. The request drops after each burst and after the last byte of a buffer. A drained buffer is released straight back to the receiver. The transfer also carries a programmable total byte count. When that count is reached, or when software withdraws the enable, the buffer being drained is discarded and the handler turns itself off. A routing input moves the request/acknowledge pair onto a second handshake channel that can be shared with another requester.

Top module: `ep_out_dma_drain`

## Requirements
- R1: `dreq` (on the selected channel) is high exactly when the handler is enabled, the oldest buffer is full, and the current burst is not exhausted. With the handler disabled, `dreq` stays low even when a buffer is full.
- R2: A read is accepted in a cycle where `rd_stb` and the selected acknowledge are high and `dreq` is high. The byte appears on `rd_data` with `rd_valid` high in the next cycle. Bytes come out in ascending address order from 0 within the buffer.
- R3: After `burst_len` accepted reads within one acknowledge assertion, `dreq` falls and further strobes are ignored. After the acknowledge falls, `dreq` returns if data remains.
- R4: Reading the last byte of a buffer (byte count from `rx_len`) drops `dreq` until the acknowledge falls. The same read gives a one-cycle `buf_clr` pulse and sets the buffer's `buf_free` bit.
- R5: Slot 0 is drained first after reset, and then the two slots alternate. The receiver fills them in the same alternating order. `buf_clr_sel` gives the released slot index (0 or 1).
- R6: When the accepted reads since enable reach `total_len`, the transfer ends. The current buffer is released even if partly read, `dma_en` goes low, and `xfer_done` pulses for one cycle.
- R7: An `en_clr` pulse while enabled ends the transfer. `dma_en` goes low, and if the oldest buffer is full it is released with a `buf_clr` pulse, even if partly read.
- R8: After any termination, `dreq` stays low until a new `en_set` pulse. That pulse restarts the total count from zero.
- R9: With `route_alt` high, the handshake uses `dreq_b`/`dack_b`. `dreq_a` stays low and `dack_a` is ignored. With `route_alt` low, the roles swap.
- R10: A strobe with the acknowledge low, with no full buffer, or after the burst or transfer is exhausted produces no `rd_valid` and does not advance any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | 1 | Pulse: enable the handler |
| en_clr | input | 1 | Pulse: withdraw the enable, ending the transfer |
| route_alt | input | 1 | Selects handshake channel b instead of a |
| burst_len | input | BLW | Bytes per request burst (at least 1) |
| total_len | input | CW | Bytes in the whole transfer (at least 1) |
| rx_we | input | 1 | Receiver byte write strobe |
| rx_sel | input | 1 | Slot written or reported by the receiver |
| rx_addr | input | clog2(MAX_PKT) | Byte address inside the slot |
| rx_data | input | DW | Byte written |
| rx_done | input | 1 | Pulse: slot `rx_sel` now holds a full packet |
| rx_len | input | clog2(MAX_PKT)+1 | Byte count of that packet (at least 1) |
| buf_free | output | 2 | Per-slot free flag for the receiver |
| dreq_a | output | 1 | Request on channel a |
| dreq_b | output | 1 | Request on channel b |
| dack_a | input | 1 | Acknowledge on channel a |
| dack_b | input | 1 | Acknowledge on channel b |
| rd_stb | input | 1 | Read strobe from the DMA controller |
| rd_data | output | DW | Byte read |
| rd_valid | output | 1 | `rd_data` holds a byte from the previous cycle's strobe |
| buf_clr | output | 1 | Pulse: a slot was released |
| buf_clr_sel | output | 1 | Index of the released slot |
| dma_en | output | 1 | Handler enable state |
| xfer_done | output | 1 | Pulse: total count reached |

## Verification
The assertions assume a well-behaved receiver. It only reports a packet into a slot that is currently free, and it fills the slots in alternation. Packet lengths, `burst_len` and `total_len` are never zero, and the length settings stay stable while the handler is enabled. The bench keeps its own copy of which slot it fills next and writes only when that slot is free. It draws lengths from ranges that start at one and changes the settings only between transfers. It drives a DMA master that holds the acknowledge until the request falls, which exercises burst ends, buffer ends and terminations that land in the middle of a buffer.

// File: rtl/pp_drain_pkg.sv
package pp_drain_pkg;
  typedef logic buf_sel_t;

  function automatic buf_sel_t other_slot(buf_sel_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/pp_ram.sv
module pp_ram #(
  parameter int DW     = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_buf_track.sv
module pp_buf_track
  import pp_drain_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fill,
  input  buf_sel_t      fill_sel,
  input  logic [LW-1:0] fill_len,
  input  logic          clr,
  output logic [1:0]    full,
  output buf_sel_t      head,
  output logic [LW-1:0] head_len
);
  logic [LW-1:0] len_w [2];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic          f_q;
    logic [LW-1:0] l_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        f_q <= 1'b0;
        l_q <= '0;
      end else begin
        if (clr && head == buf_sel_t'(g)) f_q <= 1'b0;
        if (fill && fill_sel == buf_sel_t'(g)) begin
          f_q <= 1'b1;
          l_q <= fill_len;
        end
      end
    end
    assign full[g]  = f_q;
    assign len_w[g] = l_q;
  end

  always_ff @(posedge clk) begin
    if (rst)      head <= 1'b0;
    else if (clr) head <= other_slot(head);
  end

  assign head_len = len_w[head];

  // R5: the receiver only reports a packet into a free slot
  assert_fill_into_free_R5: assert property (@(posedge clk) disable iff (rst)
    fill |-> !full[fill_sel]);

  // R4: only a full slot is ever released
  assert_clear_only_full_R4: assert property (@(posedge clk) disable iff (rst)
    clr |-> full[head]);
endmodule

// File: rtl/pp_drain_ctrl.sv
module pp_drain_ctrl #(
  parameter int AW  = 6,
  parameter int BLW = 8,
  parameter int CW  = 16,
  localparam int LW = AW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_set,
  input  logic           en_clr,
  input  logic [BLW-1:0] burst_len,
  input  logic [CW-1:0]  total_len,
  input  logic           dack,
  input  logic           stb,
  input  logic           head_full,
  input  logic [LW-1:0]  head_len,
  output logic           dreq,
  output logic           acc,
  output logic [AW-1:0]  rd_ptr,
  output logic           clr,
  output logic           en_q,
  output logic           done
);
  logic [BLW-1:0] bcnt;
  logic [CW-1:0]  xcnt;
  logic           bhit;
  logic           last_buf, last_x, term_sw;

  assign term_sw  = en_q && en_clr;
  assign acc      = en_q && !en_clr && dack && stb && head_full && !bhit;
  assign last_buf = ({1'b0, rd_ptr} + 1'b1) == head_len;
  assign last_x   = (xcnt + 1'b1) == total_len;
  assign clr      = (term_sw && head_full) || (acc && (last_buf || last_x));
  assign dreq     = en_q && head_full && !bhit;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      rd_ptr <= '0;
      bcnt   <= '0;
      xcnt   <= '0;
      bhit   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!dack) begin
        bcnt <= '0;
        bhit <= 1'b0;
      end
      if (term_sw) begin
        en_q   <= 1'b0;
        rd_ptr <= '0;
        xcnt   <= '0;
      end else if (acc) begin
        rd_ptr <= (last_buf || last_x) ? '0 : rd_ptr + 1'b1;
        bcnt   <= bcnt + 1'b1;
        xcnt   <= xcnt + 1'b1;
        if ((bcnt + 1'b1) == burst_len || last_buf || last_x) bhit <= 1'b1;
        if (last_x) begin
          en_q <= 1'b0;
          xcnt <= '0;
          done <= 1'b1;
        end
      end else if (en_set && !en_q) begin
        en_q   <= 1'b1;
        xcnt   <= '0;
        rd_ptr <= '0;
      end
    end
  end

  // R3: the read that completes a burst removes the request
  assert_burst_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && (bcnt + 1'b1) == burst_len) |=> !dreq);

  // R6: reaching the total count disables the handler and flags completion
  assert_count_end_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && last_x) |=> (!en_q && done));

  // R7: withdrawing the enable ends the transfer
  assert_sw_stop_R7: assert property (@(posedge clk) disable iff (rst)
    term_sw |=> !en_q);
endmodule

// File: rtl/ep_out_dma_drain.sv
module ep_out_dma_drain
  import pp_drain_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MAX_PKT = 64,
  parameter int BLW     = 8,
  parameter int CW      = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en_set,
  input  logic                       en_clr,
  input  logic                       route_alt,
  input  logic [BLW-1:0]             burst_len,
  input  logic [CW-1:0]              total_len,
  input  logic                       rx_we,
  input  logic                       rx_sel,
  input  logic [$clog2(MAX_PKT)-1:0] rx_addr,
  input  logic [DW-1:0]              rx_data,
  input  logic                       rx_done,
  input  logic [$clog2(MAX_PKT):0]   rx_len,
  output logic [1:0]                 buf_free,
  output logic                       dreq_a,
  output logic                       dreq_b,
  input  logic                       dack_a,
  input  logic                       dack_b,
  input  logic                       rd_stb,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_valid,
  output logic                       buf_clr,
  output logic                       buf_clr_sel,
  output logic                       dma_en,
  output logic                       xfer_done
);
  localparam int AW = $clog2(MAX_PKT);
  localparam int LW = AW + 1;

  logic          dack_eff, dreq_w, acc, clr, en_q, done;
  logic [1:0]    full;
  buf_sel_t      head;
  logic [LW-1:0] head_len;
  logic [AW-1:0] rd_ptr;

  assign dack_eff = route_alt ? dack_b : dack_a;

  pp_buf_track #(.LW(LW)) u_track (
    .clk, .rst,
    .fill(rx_done), .fill_sel(rx_sel), .fill_len(rx_len),
    .clr, .full, .head, .head_len
  );

  pp_drain_ctrl #(.AW(AW), .BLW(BLW), .CW(CW)) u_ctrl (
    .clk, .rst, .en_set, .en_clr, .burst_len, .total_len,
    .dack(dack_eff), .stb(rd_stb), .head_full(full[head]), .head_len,
    .dreq(dreq_w), .acc, .rd_ptr, .clr, .en_q, .done
  );

  pp_ram #(.DW(DW), .ADDR_W(AW + 1)) u_ram (
    .clk,
    .we(rx_we), .waddr({rx_sel, rx_addr}), .wdata(rx_data),
    .re(acc), .raddr({head, rd_ptr}), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      buf_clr     <= 1'b0;
      buf_clr_sel <= 1'b0;
    end else begin
      rd_valid <= acc;
      buf_clr  <= clr;
      if (clr) buf_clr_sel <= head;
    end
  end

  assign buf_free  = ~full;
  assign dreq_a    = dreq_w && !route_alt;
  assign dreq_b    = dreq_w && route_alt;
  assign dma_en    = en_q;
  assign xfer_done = done;

  // R2: every byte out answers a strobe under acknowledge one cycle earlier
  assert_data_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_stb && dack_eff));

  // R4: a released slot is reported free on the following cycle
  assert_release_frees_R4: assert property (@(posedge clk) disable iff (rst)
    buf_clr |-> buf_free[buf_clr_sel]);
endmodule

// File: tb/test_ep_out_dma_drain.sv
`timescale 1ns/1ps
module test_ep_out_dma_drain;
  localparam int DW = 8, MAX_PKT = 64, AW = 6, LW = 7, BLW = 8, CW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, en_set, en_clr, route_alt, rx_we, rx_sel, rx_done;
  logic [BLW-1:0] burst_len;
  logic [CW-1:0]  total_len;
  logic [AW-1:0]  rx_addr;
  logic [DW-1:0]  rx_data;
  logic [LW-1:0]  rx_len;
  logic [1:0]     buf_free;
  logic dreq_a, dreq_b, dack_a, dack_b, rd_stb, rd_valid, buf_clr, buf_clr_sel, dma_en, xfer_done;
  logic [DW-1:0]  rd_data;

  ep_out_dma_drain #(.DW(DW), .MAX_PKT(MAX_PKT), .BLW(BLW), .CW(CW)) i_ep_out_dma_drain (
    .clk, .rst, .en_set, .en_clr, .route_alt, .burst_len, .total_len,
    .rx_we, .rx_sel, .rx_addr, .rx_data, .rx_done, .rx_len, .buf_free,
    .dreq_a, .dreq_b, .dack_a, .dack_b, .rd_stb, .rd_data, .rd_valid,
    .buf_clr, .buf_clr_sel, .dma_en, .xfer_done
  );

  int n_tests = 0, n_fail = 0, cyc = 0;

  bit         m_en, m_bhit;
  bit         m_full [2];
  int         m_len [2];
  logic [7:0] m_data [2][MAX_PKT];
  int         m_head, m_ptr, m_x, m_total, m_burst, m_bcnt, fill_next;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_dreq();
    return m_en && m_full[m_head] && !m_bhit;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic fill(input int len);
    int sel = fill_next;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_we = 1; rx_sel = sel[0]; rx_addr = AW'(i); rx_data = DW'($urandom);
      m_data[sel][i] = rx_data;
    end
    @(negedge clk);
    rx_we = 0; rx_done = 1; rx_sel = sel[0]; rx_len = LW'(len);
    @(negedge clk);
    rx_done = 0;
    m_full[sel] = 1; m_len[sel] = len; fill_next ^= 1;
    chk(buf_free[sel] == 1'b0, "R5 slot marked full", buf_free[sel], 0);
  endtask

  task automatic set_len(input int b, input int t);
    m_burst = b; m_total = t;
    burst_len = BLW'(b); total_len = CW'(t);
  endtask

  task automatic enable();
    @(negedge clk); en_set = 1;
    @(negedge clk); en_set = 0;
    if (!m_en) begin m_en = 1; m_x = 0; m_ptr = 0; end
    chk(dma_en == 1'b1, "R8 enable", dma_en, 1);
  endtask

  task automatic disable_h();
    bit ce = 0;
    int sel = m_head;
    @(negedge clk); en_clr = 1;
    @(negedge clk); en_clr = 0;
    if (m_en) begin
      ce = m_full[m_head];
      if (ce) begin m_full[m_head] = 0; m_head ^= 1; end
      m_en = 0; m_ptr = 0; m_x = 0;
    end
    chk(dma_en == 1'b0, "R7 handler off", dma_en, 0);
    chk(buf_clr == ce, "R7 release pulse", buf_clr, ce);
    if (ce) chk(buf_clr_sel == sel[0], "R7 released slot", buf_clr_sel, sel);
  endtask

  task automatic burst(input int maxr, input bit alt);
    int k = 0;
    @(negedge clk);
    if (alt) dack_b = 1; else dack_a = 1;
    while (k < maxr) begin
      logic dq, dother;
      bit lb, lx;
      int h;
      dq = alt ? dreq_b : dreq_a;
      dother = alt ? dreq_a : dreq_b;
      chk(dq == exp_dreq(), "R1 request level", dq, exp_dreq());
      chk(dother == 1'b0, "R9 unused channel quiet", dother, 0);
      if (!exp_dreq()) break;
      rd_stb = 1;
      @(negedge clk);
      rd_stb = 0;
      h = m_head;
      chk(rd_valid == 1'b1, "R2 read valid", rd_valid, 1);
      chk(rd_data == m_data[h][m_ptr], "R2 read data", rd_data, m_data[h][m_ptr]);
      lb = (m_ptr + 1 == m_len[h]);
      lx = (m_x + 1 == m_total);
      m_ptr++; m_x++; m_bcnt++;
      if (m_bcnt == m_burst || lb || lx) m_bhit = 1;
      if (lb || lx) begin m_full[h] = 0; m_head ^= 1; m_ptr = 0; end
      if (lx) begin m_en = 0; m_x = 0; end
      chk(buf_clr == (lb || lx), "R4 release pulse", buf_clr, lb || lx);
      if (lb || lx) chk(buf_clr_sel == h[0], "R5 released slot order", buf_clr_sel, h);
      chk(dma_en == m_en, "R6 enable state", dma_en, m_en);
      chk(xfer_done == lx, "R6 done pulse", xfer_done, lx);
      k++;
    end
    if (!exp_dreq()) begin
      rd_stb = 1;
      @(negedge clk);
      rd_stb = 0;
      chk(rd_valid == 1'b0, "R10 strobe ignored", rd_valid, 0);
      chk(buf_clr == 1'b0, "R3 no count after burst end", buf_clr, 0);
    end
    dack_a = 0; dack_b = 0;
    @(negedge clk);
    m_bhit = 0; m_bcnt = 0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst = 1; en_set = 0; en_clr = 0; route_alt = 0; rx_we = 0; rx_sel = 0;
    rx_addr = '0; rx_data = '0; rx_done = 0; rx_len = '0; dack_a = 0; dack_b = 0; rd_stb = 0;
    m_en = 0; m_bhit = 0; m_full[0] = 0; m_full[1] = 0; m_len[0] = 0; m_len[1] = 0;
    m_head = 0; m_ptr = 0; m_x = 0; m_bcnt = 0; fill_next = 0;
    set_len(3, 100);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(dreq_a == 0 && dreq_b == 0, "R1 reset request", dreq_a, 0);
    chk(buf_free == 2'b11, "R5 reset free", buf_free, 3);
    chk(dma_en == 0, "R8 reset disabled", dma_en, 0);

    // R1: full buffer but handler off; R10: strobes ignored
    fill(5);
    repeat (2) @(negedge clk);
    chk(dreq_a == 0, "R1 no request while disabled", dreq_a, 0);
    dack_a = 1; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0;
    @(negedge clk);
    dack_a = 0;
    chk(rd_valid == 0, "R10 strobe without enable", rd_valid, 0);

    // R3, R4: burst of 3 then the remaining 2 bytes end the buffer
    enable();
    burst(10, 0);
    chk(m_full[0] == 1 && m_ptr == 3, "R3 burst length", m_ptr, 3);
    burst(10, 0);
    chk(buf_free == 2'b11, "R4 buffer released", buf_free, 3);

    // R5: two packets drained in fill order (slot 1 then slot 0)
    fill(4); fill(2);
    burst(10, 0); burst(10, 0); burst(10, 0);
    chk(m_full[0] == 0 && m_full[1] == 0, "R5 both drained", buf_free, 3);

    // R6: total count ends in the middle of a buffer
    disable_h();
    set_len(8, 4);
    enable();
    fill(6);
    burst(10, 0);
    chk(buf_free[m_head ^ 1] == 1'b1, "R6 partial buffer released", buf_free, 3);
    // R8: no request until enabled again
    fill(3);
    repeat (3) @(negedge clk);
    chk(dreq_a == 0, "R8 stays off after end", dreq_a, 0);
    set_len(2, 50);
    enable();
    chk(dreq_a == 1, "R8 request after re-enable", dreq_a, 1);

    // R7: software stop in the middle of a buffer
    burst(1, 0);
    disable_h();
    chk(buf_free == 2'b11, "R7 buffer discarded", buf_free, 3);

    // R9: alternate channel
    route_alt = 1;
    set_len(4, 60);
    fill(7);
    enable();
    dack_a = 1; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; dack_a = 0;
    @(negedge clk);
    chk(rd_valid == 0, "R9 channel a acknowledge ignored", rd_valid, 0);
    burst(10, 1); burst(10, 1);
    disable_h();
    route_alt = 0;

    // random rounds
    for (int r = 0; r < 25; r++) begin
      set_len(1 + $urandom % 6, 1 + $urandom % 40);
      route_alt = $urandom % 2;
      enable();
      for (int it = 0; it < 60 && m_en; it++) begin
        if (!m_full[fill_next] && (($urandom % 2) == 1 || !m_full[m_head]))
          fill(1 + $urandom % 20);
        if ($urandom % 12 == 0) disable_h();
        else burst(1 + $urandom % 10, route_alt);
      end
      if (m_en) disable_h();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule